// File: doc/BRIEF.md
# Two-Stage Instruction Fetch Sequencer

This block is the instruction front end of a small core whose program store sits on its own bus, apart from data memory. It keeps the fetch address in a program counter and puts that address on a 12-bit program memory port. The word that comes back is captured into an instruction register, which feeds the execute stage. Fetching the next word therefore overlaps with executing the current one. Instruction fetch never waits for a data access. With no redirect, one instruction is issued every cycle.

The execute stage can steer fetch in two ways. It can request a taken branch with a target address. It can also write the data-memory location where the program counter is mapped. Either way, the word already fetched is thrown away and replaced by a no-operation bubble. Fetch then restarts at the new address, so a redirecting instruction costs one extra cycle. The depth of program memory is a parameter, and the counter width follows from it.

Top module: `fetch_sequencer`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block loads `pmem_addr` with the reset vector, `exec_instr` with the bubble word 12'h000, and clears `exec_valid`. The first fetched word is therefore issued one cycle after reset is released.
- R2: At an edge with no redirect, `pmem_addr` advances by exactly one.
- R3: At an edge with no redirect, a `pmem_addr` of DEPTH-1 is followed by address 0.
- R4: At an edge with no redirect, the following happens in the next cycle. `exec_instr` equals the `pmem_data` present at that edge. `exec_pc` equals the `pmem_addr` present at that edge. `exec_valid` is 1.
- R5: At an edge where `br_take` is 1, the following happens in the next cycle. `pmem_addr` equals `br_target`. `exec_valid` is 0 and `exec_instr` is 12'h000, which is the bubble. The target word is issued one cycle after that.
- R6: At an edge where `dwr_en` is 1, `dwr_addr` equals PC_REG_ADDR (default 5'h02) and `br_take` is 0, fetch is redirected like a branch. The new fetch address is `dwr_data` zero-extended to the counter width, and a bubble is issued.
- R7: A data write to any address other than PC_REG_ADDR has no effect on `pmem_addr`, `exec_instr`, `exec_valid` or `exec_pc`.
- R8: When a branch and a write to the counter location arrive at the same edge, the branch target is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pmem_addr | output | PC_W | Fetch address to program memory (the program counter) |
| pmem_data | input | 12 | Instruction word read from program memory at `pmem_addr` |
| exec_instr | output | 12 | Instruction word handed to the execute stage |
| exec_pc | output | PC_W | Address the issued word was fetched from |
| exec_valid | output | 1 | High when `exec_instr` is a fetched word, low for a bubble |
| br_take | input | 1 | Taken-branch request from the execute stage |
| br_target | input | PC_W | Branch destination address |
| dwr_en | input | 1 | Data-memory write strobe |
| dwr_addr | input | DADDR_W | Data-memory write address |
| dwr_data | input | DATA_W | Data-memory write value |

## Verification
The bench builds the block with DEPTH = 512, which is the smaller program store. It sets the reset vector to 9'h1F8, so the counter wraps from 511 to 0 within a few cycles of reset. An 8-bit write to the counter location fills only part of the 9-bit counter in this build, so a zero-extended write can be told apart from a plain copy. Directed redirects cover several cases: back-to-back branches during a bubble, a branch and a counter write on the same edge, and writes to neighbouring data addresses. A long random phase then mixes all three request kinds against the reference model.

// File: rtl/fseq_pkg.sv
// Shared constants and types for the fetch sequencer.
package fseq_pkg;
    localparam int INSTR_W = 12;
    localparam logic [INSTR_W-1:0] NOP_WORD = '0;

    // Source of the next fetch address
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_REGWR  = 2'd2
    } pc_src_e;
endpackage

// File: rtl/fseq_redirect.sv
// Redirect decode: turns branch requests and data writes aimed at the
// counter's data address into a single redirect strobe and target.
// Assumes requests are valid for the whole cycle; branch has priority.
module fseq_redirect
    import fseq_pkg::*;
#(
    parameter int PC_W        = 10,
    parameter int DATA_W      = 8,
    parameter int DADDR_W     = 5,
    parameter int PC_REG_ADDR = 2
) (
    input  logic               br_take,
    input  logic [PC_W-1:0]    br_target,
    input  logic               dwr_en,
    input  logic [DADDR_W-1:0] dwr_addr,
    input  logic [DATA_W-1:0]  dwr_data,
    output logic               redirect,
    output logic [PC_W-1:0]    new_pc,
    output pc_src_e            src
);
    localparam logic [DADDR_W-1:0] REG_ADDR = DADDR_W'(PC_REG_ADDR);

    logic          hit_reg;
    logic [PC_W-1:0] reg_value;

    // Detect a data write landing on the counter's mapped location
    always_comb begin
        hit_reg = dwr_en && (dwr_addr == REG_ADDR);
    end

    // Size the written byte to the counter: extend or truncate by width
    generate
        if (PC_W >= DATA_W) begin : g_ext
            assign reg_value = {{(PC_W-DATA_W){1'b0}}, dwr_data};
        end else begin : g_trunc
            assign reg_value = dwr_data[PC_W-1:0];
        end
    endgenerate

    // Pick the redirect source, branch first
    always_comb begin
        if (br_take) begin
            src    = SRC_BRANCH;
            new_pc = br_target;
        end else if (hit_reg) begin
            src    = SRC_REGWR;
            new_pc = reg_value;
        end else begin
            src    = SRC_SEQ;
            new_pc = '0;
        end
        redirect = (src != SRC_SEQ);
    end
endmodule

// File: rtl/fseq_pc.sv
// Program counter: loads the reset vector, steps by one with wrap at the
// program store depth, or loads a redirect target.
// Assumes redirect targets are already below DEPTH.
module fseq_pc #(
    parameter int DEPTH     = 1024,
    parameter int PC_W      = 10,
    parameter int RESET_VEC = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect,
    input  logic [PC_W-1:0] new_pc,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] LAST_ADDR = PC_W'(DEPTH - 1);
    localparam logic [PC_W-1:0] RST_ADDR  = PC_W'(RESET_VEC);
    localparam bit POW2 = ((1 << PC_W) == DEPTH);

    logic [PC_W-1:0] pc_inc;

    // Sequential successor; power-of-two depths wrap for free
    generate
        if (POW2) begin : g_natural
            assign pc_inc = pc + PC_W'(1);
        end else begin : g_compare
            assign pc_inc = (pc == LAST_ADDR) ? '0 : pc + PC_W'(1);
        end
    endgenerate

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n)        pc <= RST_ADDR;
        else if (redirect) pc <= new_pc;
        else               pc <= pc_inc;
    end
endmodule

// File: rtl/fseq_ir.sv
// Instruction register: captures the fetched word and its address, or
// loads a bubble when the fetched word is discarded.
// Assumes the program store returns the word in the same cycle.
module fseq_ir
    import fseq_pkg::*;
#(
    parameter int PC_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               redirect,
    input  logic [INSTR_W-1:0] fetch_word,
    input  logic [PC_W-1:0]    fetch_pc,
    output logic [INSTR_W-1:0] instr,
    output logic [PC_W-1:0]    instr_pc,
    output logic               instr_valid
);
    // Word and valid flag: bubble on reset or discard
    always_ff @(posedge clk) begin
        if (!rst_n || redirect) begin
            instr       <= NOP_WORD;
            instr_valid <= 1'b0;
        end else begin
            instr       <= fetch_word;
            instr_valid <= 1'b1;
        end
    end

    // Address tag travelling with the word
    always_ff @(posedge clk) begin
        if (!rst_n) instr_pc <= '0;
        else        instr_pc <= fetch_pc;
    end
endmodule

// File: rtl/fetch_sequencer.sv
// Two-stage fetch sequencer top: counter drives the program port, the
// instruction register issues to execute, redirects insert one bubble.
// Assumes a combinational-read program store and RESET_VEC < DEPTH.
module fetch_sequencer
    import fseq_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int RESET_VEC   = 0,
    parameter int DATA_W      = 8,
    parameter int DADDR_W     = 5,
    parameter int PC_REG_ADDR = 2,
    localparam int PC_W       = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PC_W-1:0]    pmem_addr,
    input  logic [INSTR_W-1:0] pmem_data,
    output logic [INSTR_W-1:0] exec_instr,
    output logic [PC_W-1:0]    exec_pc,
    output logic               exec_valid,
    input  logic               br_take,
    input  logic [PC_W-1:0]    br_target,
    input  logic               dwr_en,
    input  logic [DADDR_W-1:0] dwr_addr,
    input  logic [DATA_W-1:0]  dwr_data
);
    logic            redirect;
    logic [PC_W-1:0] new_pc;
    logic [PC_W-1:0] pc;
    pc_src_e         src;

    fseq_redirect #(
        .PC_W(PC_W), .DATA_W(DATA_W), .DADDR_W(DADDR_W), .PC_REG_ADDR(PC_REG_ADDR)
    ) u_redirect (
        .br_take  (br_take),
        .br_target(br_target),
        .dwr_en   (dwr_en),
        .dwr_addr (dwr_addr),
        .dwr_data (dwr_data),
        .redirect (redirect),
        .new_pc   (new_pc),
        .src      (src)
    );

    fseq_pc #(
        .DEPTH(DEPTH), .PC_W(PC_W), .RESET_VEC(RESET_VEC)
    ) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .redirect(redirect),
        .new_pc  (new_pc),
        .pc      (pc)
    );

    fseq_ir #(
        .PC_W(PC_W)
    ) u_ir (
        .clk        (clk),
        .rst_n      (rst_n),
        .redirect   (redirect),
        .fetch_word (pmem_data),
        .fetch_pc   (pc),
        .instr      (exec_instr),
        .instr_pc   (exec_pc),
        .instr_valid(exec_valid)
    );

    // Fetch address is the counter itself
    assign pmem_addr = pc;
endmodule

// File: rtl/fseq_checker.sv
// Port-level temporal checks for fetch_sequencer, attached by bind.
module fseq_checker #(
    parameter int DEPTH       = 1024,
    parameter int DATA_W      = 8,
    parameter int DADDR_W     = 5,
    parameter int PC_REG_ADDR = 2,
    localparam int PC_W       = $clog2(DEPTH)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PC_W-1:0]    pmem_addr,
    input logic [11:0]        pmem_data,
    input logic [11:0]        exec_instr,
    input logic [PC_W-1:0]    exec_pc,
    input logic               exec_valid,
    input logic               br_take,
    input logic [PC_W-1:0]    br_target,
    input logic               dwr_en,
    input logic [DADDR_W-1:0] dwr_addr,
    input logic [DATA_W-1:0]  dwr_data
);
    localparam logic [PC_W-1:0] LAST_ADDR = PC_W'(DEPTH - 1);

    logic reg_hit;
    logic quiet;
    logic [PC_W-1:0] succ;
    assign reg_hit = dwr_en && (dwr_addr == DADDR_W'(PC_REG_ADDR));
    assign quiet   = !br_take && !reg_hit;
    assign succ    = (pmem_addr == LAST_ADDR) ? '0 : pmem_addr + PC_W'(1);

    // R2 R3
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> pmem_addr == $past(succ));

    // R4
    issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> exec_valid && exec_instr == $past(pmem_data) && exec_pc == $past(pmem_addr));

    // R5
    branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_take |=> pmem_addr == $past(br_target) && !exec_valid && exec_instr == 12'h000);

    // R6
    regwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_hit && !br_take) |=> pmem_addr == PC_W'($past(dwr_data)) && !exec_valid);

    // R7
    other_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr_en && !reg_hit && !br_take) |=> exec_valid);
endmodule

bind fetch_sequencer fseq_checker #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .DADDR_W(DADDR_W), .PC_REG_ADDR(PC_REG_ADDR)
) u_fseq_checker (
    .clk(clk), .rst_n(rst_n), .pmem_addr(pmem_addr), .pmem_data(pmem_data),
    .exec_instr(exec_instr), .exec_pc(exec_pc), .exec_valid(exec_valid),
    .br_take(br_take), .br_target(br_target), .dwr_en(dwr_en),
    .dwr_addr(dwr_addr), .dwr_data(dwr_data)
);

// File: tb/test_fetch_sequencer.sv
module test_fetch_sequencer;
    localparam int DEPTH = 512;
    localparam int PC_W  = 9;
    localparam int RV    = 'h1F8;
    localparam int PCREG = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  pmem_addr;
    logic [11:0]      pmem_data;
    logic [11:0]      exec_instr;
    logic [PC_W-1:0]  exec_pc;
    logic             exec_valid;
    logic             br_take = 1'b0;
    logic [PC_W-1:0]  br_target = '0;
    logic             dwr_en = 1'b0;
    logic [4:0]       dwr_addr = '0;
    logic [7:0]       dwr_data = '0;

    logic [11:0] rom [DEPTH];

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // behavioural reference state
    int m_pc, m_ir, m_valid, m_epc;

    always #4 clk = ~clk;

    assign pmem_data = rom[pmem_addr];

    fetch_sequencer #(
        .DEPTH(DEPTH), .RESET_VEC(RV), .DATA_W(8), .DADDR_W(5), .PC_REG_ADDR(PCREG)
    ) i_fetch_sequencer (
        .clk(clk), .rst_n(rst_n), .pmem_addr(pmem_addr), .pmem_data(pmem_data),
        .exec_instr(exec_instr), .exec_pc(exec_pc), .exec_valid(exec_valid),
        .br_take(br_take), .br_target(br_target), .dwr_en(dwr_en),
        .dwr_addr(dwr_addr), .dwr_data(dwr_data)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "pmem_addr", int'(pmem_addr), m_pc);
        chk(tag, "exec_valid", int'(exec_valid), m_valid);
        chk(tag, "exec_instr", int'(exec_instr), m_ir);
        if (m_valid != 0) chk(tag, "exec_pc", int'(exec_pc), m_epc);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; br_take = 0; dwr_en = 0;
        repeat (2) @(posedge clk);
        m_pc = RV; m_ir = 0; m_valid = 0; m_epc = 0;
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
    endtask

    // apply one cycle of requests, advance the model, compare
    task automatic step(string tag, bit br, int tgt, bit we, int wa, int wd);
        bit redir;
        int npc;
        br_take = br; br_target = PC_W'(tgt);
        dwr_en = we; dwr_addr = 5'(wa); dwr_data = 8'(wd);
        @(posedge clk);
        redir = br || (we && wa == PCREG);
        npc = br ? tgt : (wd & 'hFF);
        m_epc = m_pc;
        m_ir = redir ? 0 : int'(rom[m_pc]);
        m_valid = redir ? 0 : 1;
        m_pc = redir ? npc : (m_pc + 1) % DEPTH;
        @(negedge clk);
        compare(tag);
        br_take = 0; dwr_en = 0;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) rom[i] = 12'((i * 37 + 5) ^ (i << 3));
        do_reset();
        // first fetched word appears one cycle after release (R1), then sequential run across the wrap (R2, R3, R4)
        for (int i = 0; i < 14; i++) step("R3", 0, 0, 0, 0, 0);
        // branch with bubble (R5), back-to-back branch during the bubble
        step("R5", 1, 'h40, 0, 0, 0);
        step("R5", 1, 'h1FF, 0, 0, 0);
        for (int i = 0; i < 3; i++) step("R5", 0, 0, 0, 0, 0);
        // write to the counter location, zero-extended (R6)
        step("R6", 0, 0, 1, PCREG, 'h9C);
        for (int i = 0; i < 2; i++) step("R6", 0, 0, 0, 0, 0);
        // writes to other data addresses are ignored (R7)
        step("R7", 0, 0, 1, 3, 'h55);
        step("R7", 0, 0, 1, 0, 'hFF);
        step("R7", 0, 0, 1, 'h12, 'h01);
        // simultaneous branch and counter write: branch wins (R8)
        step("R8", 1, 'h100, 1, PCREG, 'h11);
        step("R8", 0, 0, 0, 0, 0);
        // reset in mid-run (R1)
        do_reset();
        step("R4", 0, 0, 0, 0, 0);
        // random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 8);
            if (r == 0)      step("R5", 1, int'($urandom % DEPTH), 0, 0, 0);
            else if (r == 1) step("R6", 0, 0, 1, PCREG, int'($urandom % 256));
            else if (r == 2) step("R7", 0, 0, 1, 3 + int'($urandom % 20), int'($urandom % 256));
            else if (r == 3) step("R8", 1, int'($urandom % DEPTH), 1, PCREG, int'($urandom % 256));
            else             step("R4", 0, 0, 0, 0, 0);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule